// File: doc/BRIEF.md
# DMA Channel Mode and Status Register

This block is the 16-bit mode and status register of a single DMA channel, along with the small sequencing logic that controls its two flags. Software writes the upper byte to choose how the channel moves data and to start it:

- request source: automatic or from an external pin;
- bus usage: cycle stealing or burst;
- transfer unit: single transfers or blocks;
- addressing: single-address or dual-address;
- whether the request-acknowledge and transfer-end pins are driven.

The block decodes these fields into separate control outputs for the transfer engine. It also conditions the active-low external request pin, by level or by falling edge, into a request signal.

The transfer engine reports four events: the transfer count is exhausted, a repeat area has overflowed, a block has ended, and a non-maskable interrupt has occurred. The count, overflow and interrupt events stop the channel at once. Standby also stops it at once.

A software stop behaves differently by mode. In block mode it is held pending until the current block ends. In any other mode it takes effect on the next clock edge.

The channel-active bit is driven by a three-state machine:

| State | Meaning |
|---|---|
| `CH_IDLE` | Channel stopped |
| `CH_RUN` | Channel running |
| `CH_STOP_PEND` | Running, with a software stop deferred to the end of the block |

| Transition | Condition |
|---|---|
| start: `CH_IDLE`→`CH_RUN` | Write with bit 15 = 1 and no stop event |
| hard stop: `CH_RUN`/`CH_STOP_PEND`→`CH_IDLE` | Any of: count done, overflow, interrupt, standby |
| soft stop: `CH_RUN`→`CH_IDLE` | Write with bit 15 = 0, not in block mode |
| defer: `CH_RUN`→`CH_STOP_PEND` | Write with bit 15 = 0, in block mode |
| block end: `CH_STOP_PEND`→`CH_IDLE` | End of the current block |
| resume: `CH_STOP_PEND`→`CH_RUN` | Write with bit 15 = 1 |

The block-error flag sets when the interrupt arrives while a block transfer is running. It can be cleared only by a write of 0 that follows a read which returned it as 1.

Top module: `dma_mode_ctl`

## Requirements
- R1: After reset every register bit reads 0 (`cpu_rdata` = 0x0000), and every decoded output and `ext_req` is 0.
- R2: A write stores `cpu_wdata` bits 13..8 in the register, and they read back at the same positions from the next cycle: bit 13 = acknowledge-pin enable, bit 12 = end-pin enable, bit 11 = sense select, bit 10 = address mode, bits 9:8 = mode. Bits 7..0 read 0.
- R3: The decoded outputs follow the stored fields.
  - Bit 10 = 1 drives `single_addr` = 1.
  - Mode 00 = automatic request, cycle steal.
  - Mode 01 = automatic request, burst (`burst_mode` = 1).
  - Mode 10 = external request, cycle steal (`ext_req_mode` = 1).
  - Mode 11 = external request, block (`ext_req_mode` = `block_mode` = 1).
- R4: A write with bit 15 = 1 sets `active` on the next edge. While `active` is 1, a pulse on `count_done`, `rpt_ovf`, `nmi` or `standby` clears it on the next edge. Each of these events also overrides a start written in the same cycle.
- R5: When the mode is not 11, a write with bit 15 = 0 while the channel is active clears bit 15 on the next edge.
- R6: When the mode is 11, a write with bit 15 = 0 while the channel is active leaves bit 15 reading 1. Bit 15 reads 0 only after the edge on which `blk_end` is high.
- R7: `nmi` sets bit 14 (`blk_err`) only while `active` is 1 and the mode is 11. An `nmi` in any other mode leaves bit 14 at 0.
- R8: Bit 14 clears only on a write of 0 to bit 14 whose most recent preceding read returned bit 14 = 1. Any write consumes that arming. Writing 1 to bit 14 never changes it.
- R9: When the bit-14 set condition and an armed clearing write occur in the same cycle, bit 14 ends at 1.
- R10: With bit 11 = 0 (level sense), `ext_req` equals the inverse of `xreq_n` delayed by two clock edges, while the channel is active in an external-request mode.
- R11: With bit 11 = 1 (falling-edge sense), a high-to-low change on `xreq_n` gives `ext_req` = 1 for exactly one cycle, starting two edges later.
- R12: `ext_req` stays 0 when `active` is 0 or when the mode is 00 or 01, whatever the state of `xreq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby entry; stops the channel |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data |
| count_done | input | 1 | Programmed transfer count completed |
| rpt_ovf | input | 1 | Repeat-area overflow halt |
| blk_end | input | 1 | Current block finished |
| nmi | input | 1 | Non-maskable interrupt event |
| xreq_n | input | 1 | External request pin, active low |
| active | output | 1 | Channel enabled (bit 15) |
| blk_err | output | 1 | Block-error flag (bit 14) |
| ack_pin_en | output | 1 | Request-acknowledge pin output enable |
| tend_pin_en | output | 1 | Transfer-end pin output enable |
| single_addr | output | 1 | Single-address mode selected |
| burst_mode | output | 1 | Burst bus usage selected |
| ext_req_mode | output | 1 | Requests come from the external pin |
| block_mode | output | 1 | Block transfer mode selected |
| ext_req | output | 1 | Conditioned external request |

## Verification
If the channel state machine is in the wrong state, bit 15 shows it on the very next read. A deferred stop that drops early makes bit 15 read 0 before `blk_end`. A stop that is never applied keeps bit 15 at 1 after a count, overflow, interrupt or standby pulse.

A bad arming latch shows within one read-write pair:

- a missing arm leaves bit 14 set after a legitimate clear sequence;
- a stale arm clears bit 14 on a write that had no read before it.

Errors in the request conditioner show as `ext_req` arriving one edge early or late against the two-edge latency. In edge mode they also show as a pulse that lasts longer than one cycle.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;

    localparam int REG_W      = 16;
    localparam int BIT_ACT    = 15;
    localparam int BIT_ERR    = 14;
    localparam int BIT_ACKEN  = 13;
    localparam int BIT_TENDEN = 12;
    localparam int BIT_SENSE  = 11;
    localparam int BIT_AMS    = 10;
    localparam int BIT_MODE   = 8;

    typedef enum logic [1:0] {
        CH_IDLE      = 2'd0,
        CH_RUN       = 2'd1,
        CH_STOP_PEND = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        XM_AUTO_CS    = 2'b00,
        XM_AUTO_BURST = 2'b01,
        XM_EXT_CS     = 2'b10,
        XM_EXT_BLOCK  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic       ack_en;
        logic       tend_en;
        logic       edge_sense;
        logic       single_addr;
        xfer_mode_e mode;
    } cfg_t;

endpackage

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_act,
    input  logic block_mode,
    input  logic hw_stop,
    input  logic blk_end,
    output logic active
);

    ch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (!hw_stop && wr_en && wr_act) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (hw_stop)                state_d = CH_IDLE;
                else if (wr_en && !wr_act)  state_d = block_mode ? CH_STOP_PEND : CH_IDLE;
            end
            CH_STOP_PEND: begin
                if (hw_stop || blk_end)     state_d = CH_IDLE;
                else if (wr_en && wr_act)   state_d = CH_RUN;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q != CH_IDLE);
    end

    // R4
    hw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stop |=> !active);

    // R6
    defer_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && wr_en && !wr_act && block_mode && !hw_stop)
        |=> (state_q == CH_STOP_PEND && active));

    // R5
    soft_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && wr_en && !wr_act && !block_mode && !hw_stop)
        |=> !active);

endmodule

// File: rtl/dma_blkerr_flag.sv
module dma_blkerr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic set_ev,
    output logic flag
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= 1'b0;
        end else if (rd_en && flag) begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (wr_en && armed_q && !wr_bit) begin
            flag <= 1'b0;
        end
    end

    // R8
    armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(armed_q && wr_en && !wr_bit));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);

endmodule

// File: rtl/dma_req_cond.sv
module dma_req_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_pin,
    input  logic edge_sense,
    input  logic enable,
    output logic req
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;
    logic         raw_req;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= req_n_pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[MSB-1:0], req_n_pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[MSB];
    end

    always_comb begin
        raw_req = edge_sense ? (prev_q && !sync_q[MSB]) : !sync_q[MSB];
        req     = enable && raw_req;
    end

    // R11
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sense && $past(edge_sense) && req) |-> !$past(req));

endmodule

// File: rtl/dma_mode_ctl.sv
module dma_mode_ctl
    import dma_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             count_done,
    input  logic             rpt_ovf,
    input  logic             blk_end,
    input  logic             nmi,
    input  logic             xreq_n,
    output logic             active,
    output logic             blk_err,
    output logic             ack_pin_en,
    output logic             tend_pin_en,
    output logic             single_addr,
    output logic             burst_mode,
    output logic             ext_req_mode,
    output logic             block_mode,
    output logic             ext_req
);

    cfg_t cfg_q;
    logic hw_stop;
    logic err_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cpu_wr) begin
            cfg_q.ack_en      <= cpu_wdata[BIT_ACKEN];
            cfg_q.tend_en     <= cpu_wdata[BIT_TENDEN];
            cfg_q.edge_sense  <= cpu_wdata[BIT_SENSE];
            cfg_q.single_addr <= cpu_wdata[BIT_AMS];
            cfg_q.mode        <= xfer_mode_e'(cpu_wdata[BIT_MODE+1:BIT_MODE]);
        end
    end

    always_comb begin
        ack_pin_en   = cfg_q.ack_en;
        tend_pin_en  = cfg_q.tend_en;
        single_addr  = cfg_q.single_addr;
        burst_mode   = (cfg_q.mode == XM_AUTO_BURST);
        ext_req_mode = (cfg_q.mode == XM_EXT_CS) || (cfg_q.mode == XM_EXT_BLOCK);
        block_mode   = (cfg_q.mode == XM_EXT_BLOCK);
        hw_stop      = count_done || rpt_ovf || nmi || standby;
        err_set      = nmi && active && block_mode;
    end

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_wr),
        .wr_act     (cpu_wdata[BIT_ACT]),
        .block_mode (block_mode),
        .hw_stop    (hw_stop),
        .blk_end    (blk_end),
        .active     (active)
    );

    dma_blkerr_flag u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (cpu_rd),
        .wr_en  (cpu_wr),
        .wr_bit (cpu_wdata[BIT_ERR]),
        .set_ev (err_set),
        .flag   (blk_err)
    );

    dma_req_cond #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n_pin  (xreq_n),
        .edge_sense (cfg_q.edge_sense),
        .enable     (active && ext_req_mode),
        .req        (ext_req)
    );

    always_comb begin
        cpu_rdata              = '0;
        cpu_rdata[BIT_ACT]     = active;
        cpu_rdata[BIT_ERR]     = blk_err;
        cpu_rdata[BIT_ACKEN]   = cfg_q.ack_en;
        cpu_rdata[BIT_TENDEN]  = cfg_q.tend_en;
        cpu_rdata[BIT_SENSE]   = cfg_q.edge_sense;
        cpu_rdata[BIT_AMS]     = cfg_q.single_addr;
        cpu_rdata[BIT_MODE+1:BIT_MODE] = cfg_q.mode;
    end

    // R12
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active || !ext_req_mode) |-> !ext_req);

endmodule

// File: tb/dma_mode_ctl_test.sv
module dma_mode_ctl_test;

    typedef struct {
        logic [15:0] exp;
        bit          kind;
        string       rq;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 0, cpu_rd = 0, cpu_wr = 0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        count_done = 0, rpt_ovf = 0, blk_end = 0, nmi = 0, xreq_n = 1;
    logic        active, blk_err, ack_pin_en, tend_pin_en, single_addr;
    logic        burst_mode, ext_req_mode, block_mode, ext_req;

    item_t queue_q[$];
    bit    smp = 0;
    bit    done = 0;
    int    n_cmp = 0;
    int    n_bad = 0;

    always #4 clk = ~clk;

    dma_mode_ctl uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .count_done(count_done), .rpt_ovf(rpt_ovf), .blk_end(blk_end),
        .nmi(nmi), .xreq_n(xreq_n), .active(active), .blk_err(blk_err),
        .ack_pin_en(ack_pin_en), .tend_pin_en(tend_pin_en),
        .single_addr(single_addr), .burst_mode(burst_mode),
        .ext_req_mode(ext_req_mode), .block_mode(block_mode),
        .ext_req(ext_req)
    );

    // monitor: samples 1 ns before the rising edge
    always @(negedge clk) begin
        #3;
        if (smp && queue_q.size() > 0) begin
            item_t it;
            logic [15:0] obs;
            it  = queue_q.pop_front();
            obs = it.kind ? {9'b0, ext_req, active, blk_err, single_addr,
                             burst_mode, ext_req_mode, block_mode}
                          : cpu_rdata;
            n_cmp++;
            if (obs !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got 0x%04h expected 0x%04h", it.rq, obs, it.exp);
            end
        end
    end

    task automatic go();
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0; count_done = 0; rpt_ovf = 0;
        blk_end = 0; nmi = 0; standby = 0; smp = 0;
    endtask

    task automatic wr(input logic [15:0] d);
        go(); cpu_wr = 1; cpu_wdata = d;
    endtask

    task automatic rd_chk(input logic [15:0] e, input string rq);
        item_t it;
        go(); cpu_rd = 1; smp = 1;
        it.exp = e; it.kind = 0; it.rq = rq;
        queue_q.push_back(it);
    endtask

    task automatic out_chk(input logic [15:0] e, input string rq);
        item_t it;
        go(); smp = 1;
        it.exp = e; it.kind = 1; it.rq = rq;
        queue_q.push_back(it);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(16'h0000, "R1");
        out_chk(16'h0000, "R1");
        // R2 / R3 field storage and decode
        wr(16'h3D00);
        rd_chk(16'h3D00, "R2");
        out_chk(16'h000C, "R3");
        wr(16'h0300);
        out_chk(16'h0003, "R3");
        wr(16'h0200);
        out_chk(16'h0002, "R3");
        wr(16'h0000);
        out_chk(16'h0000, "R3");
        // R4 start and hardware stops
        wr(16'h8000);
        rd_chk(16'h8000, "R4");
        go(); count_done = 1;
        rd_chk(16'h0000, "R4");
        wr(16'h8000);
        go(); rpt_ovf = 1;
        rd_chk(16'h0000, "R4");
        wr(16'h8000);
        go(); standby = 1;
        rd_chk(16'h0000, "R4");
        wr(16'h8000); nmi = 1;
        rd_chk(16'h0000, "R4");
        // R7 negative: nmi outside block mode
        wr(16'h8000);
        go(); nmi = 1;
        rd_chk(16'h0000, "R7");
        // R5 immediate soft stop
        wr(16'h8000);
        wr(16'h0000);
        rd_chk(16'h0000, "R5");
        // R6 deferred stop in block mode
        wr(16'h8300);
        rd_chk(16'h8300, "R6");
        wr(16'h0300);
        rd_chk(16'h8300, "R6");
        go();
        rd_chk(16'h8300, "R6");
        go(); blk_end = 1;
        rd_chk(16'h0300, "R6");
        // R7 error set
        wr(16'h8300);
        go(); nmi = 1;
        out_chk(16'h0013, "R7");
        // R8 clear protocol
        wr(16'h0300);
        rd_chk(16'h4300, "R8");
        wr(16'h4300);
        rd_chk(16'h4300, "R8");
        wr(16'h0300);
        rd_chk(16'h0300, "R8");
        // R9 set beats armed clear
        wr(16'h8300);
        go(); nmi = 1;
        rd_chk(16'h4300, "R9");
        wr(16'hC300);
        rd_chk(16'hC300, "R9");
        wr(16'h8300); nmi = 1;
        rd_chk(16'h4300, "R9");
        wr(16'h0000);
        rd_chk(16'h0000, "R8");
        // R10 level sense
        wr(16'h8200);
        out_chk(16'h0022, "R10");
        go(); xreq_n = 0;
        out_chk(16'h0022, "R10");
        out_chk(16'h0062, "R10");
        out_chk(16'h0062, "R10");
        // R12 gating
        wr(16'h8000);
        out_chk(16'h0020, "R12");
        wr(16'h0200);
        out_chk(16'h0002, "R12");
        // R11 falling edge pulse
        go(); xreq_n = 1;
        wr(16'h8A00);
        repeat (4) go();
        go(); xreq_n = 0;
        out_chk(16'h0022, "R11");
        out_chk(16'h0062, "R11");
        out_chk(16'h0022, "R11");
        out_chk(16'h0022, "R11");
        go();
        go();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule